// File: doc/BRIEF.md
# Quadword Block-Move DMA Channel

This block is one channel of a memory-to-stream DMA engine. Software sets it up through three 32-bit registers: a channel control word, a memory address and a quadword count. It then moves one contiguous region of 128-bit quadwords from a request/response memory read port to a valid/ready destination stream. The transfer begins on the same register write that sets the start bit in the control word. The engine clears that bit once the last quadword has been accepted downstream, so software can poll it as a busy/done flag.

Only the contiguous (normal) transfer mode is carried out. A start request is refused when the mode field holds another encoding or the address is not quadword aligned. A refused start leaves the start bit clear and raises a sticky error flag. During a transfer the address and count registers track progress, and they can be read back at any time. The engine keeps at most one memory read outstanding. It holds a quadword on the stream for as long as the sink applies backpressure.

Top module: `qwdma_channel`

## Requirements
- R1: After reset the control, address and count readbacks are 0, the error flag is 0, and neither `mem_req` nor `st_valid` is asserted.
- R2: A write with `cfg_wr_sel` = 0 loads the control word, 1 loads the address, and 2 loads the count from data bits 15:0. While idle, each register reads back what was written, and count readback bits 31:16 are always 0.
- R3: Writing the control word with bit 8 (start) set, bits 3:2 (mode) equal to 00, an address whose bits 3:0 are zero and a nonzero count begins a transfer. Bit 8 reads 1 from the cycle after the write until completion, and `mem_req` is high in the cycle after the write.
- R4: The stream delivers exactly count quadwords. Each one is the memory response to addresses start, start+16, start+32 and so on, in that order.
- R5: Each quadword accepted by the stream advances the address by 16 (bit 31 is kept) and decrements the count by 1. At completion the count reads 0, and bit 8 reads 0 in the cycle after the last acceptance.
- R6: While `st_valid` is high and `st_ready` is low, `st_valid` stays high and `st_data` stays unchanged.
- R7: At most one memory read is outstanding. `mem_req` is never raised while a response is pending or while a quadword waits on the stream, and one read is issued per quadword.
- R8: A start with a count of 0 issues no read. Bit 8 reads 1 for one cycle and then 0.
- R9: A start with address bits 3:0 nonzero or with mode bits other than 00 issues no read and leaves bit 8 reading 0. It sets the error flag, which stays 1 until reset, including across later good transfers.
- R10: Register writes of any kind made during an active transfer have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 2 | Register select: 0 control, 1 address, 2 count |
| cfg_wr_data | input | 32 | Register write data |
| ctrl_rd | output | 32 | Control word readback (bit 8 = start/busy) |
| addr_rd | output | 32 | Current address readback |
| count_rd | output | 32 | Remaining quadword count readback |
| err_flag | output | 1 | Sticky refused-start flag |
| mem_req | output | 1 | Memory read request, one cycle per quadword |
| mem_addr | output | 31 | Byte address of the requested quadword |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 128 | Memory read data |
| st_valid | output | 1 | Stream quadword valid |
| st_data | output | 128 | Stream quadword |
| st_ready | input | 1 | Stream sink ready |

## Verification
A start write lands on one clock edge. At the next sampling point `mem_req` must be high and bit 8 must read 1; for a refused start, bit 8 must read 0 and the error flag 1. A zero-count start must show bit 8 as 1 at that point and as 0 one cycle later. With a one-cycle memory model and a ready sink, each quadword takes three cycles from request to acceptance. Bit 8 must fall exactly one sample after the final acceptance, and the bench arms a check for that very sample. A quadword held by backpressure is compared against itself at the next sample, and address and count readbacks are compared only after the transfer has finished.

// File: rtl/qwdma_pkg.sv
package qwdma_pkg;
    localparam int REG_W     = 32;
    localparam int START_BIT = 8;
    localparam int MODE_LSB  = 2;
    localparam logic [1:0] MODE_NORMAL = 2'b00;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_ADDR  = 2'd1;
    localparam logic [1:0] SEL_COUNT = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_WAIT = 3'd2,
        ST_SEND = 3'd3,
        ST_ZERO = 3'd4
    } seq_state_e;
endpackage

// File: rtl/qwdma_start_check.sv
module qwdma_start_check
    import qwdma_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int ALIGN_BITS = 4
) (
    input  logic [1:0]            mode_i,
    input  logic [ALIGN_BITS-1:0] addr_lo_i,
    input  logic [CNT_W-1:0]      cnt_i,
    output logic                  reject_o,
    output logic                  empty_o
);
    always_comb begin
        reject_o = (mode_i != MODE_NORMAL) || (addr_lo_i != '0);
        empty_o  = (cnt_i == '0);
    end
endmodule

// File: rtl/qwdma_beat_buf.sv
module qwdma_beat_buf #(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (buf_q.full && ready_i) begin
            buf_d.full = 1'b0;
        end
        if (load_i) begin
            buf_d.full = 1'b1;
            buf_d.data = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign valid_o = buf_q.full;
    assign data_o  = buf_q.data;
endmodule

// File: rtl/qwdma_seq.sv
module qwdma_seq
    import qwdma_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             reject_i,
    input  logic             empty_i,
    input  logic             rsp_valid_i,
    input  logic             pop_i,
    output logic             mem_req_o,
    output logic [30:0]      mem_addr_o,
    output logic             load_o,
    output logic [REG_W-1:0] ctrl_o,
    output logic [REG_W-1:0] addr_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             err_o
);
    localparam int BEAT_BYTES = DATA_W / 8;

    typedef struct packed {
        seq_state_e       st;
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] addr;
        logic [CNT_W-1:0] cnt;
        logic             err;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        mem_req_o = 1'b0;
        load_o    = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (wr_en_i) begin
                    case (wr_sel_i)
                        SEL_CTRL: begin
                            s_d.ctrl = wr_data_i;
                            if (wr_data_i[START_BIT]) begin
                                if (reject_i) begin
                                    s_d.ctrl[START_BIT] = 1'b0;
                                    s_d.err             = 1'b1;
                                end else if (empty_i) begin
                                    s_d.st = ST_ZERO;
                                end else begin
                                    s_d.st = ST_REQ;
                                end
                            end
                        end
                        SEL_ADDR:  s_d.addr = wr_data_i;
                        SEL_COUNT: s_d.cnt  = wr_data_i[CNT_W-1:0];
                        default: ;
                    endcase
                end
            end
            ST_REQ: begin
                mem_req_o = 1'b1;
                s_d.st    = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid_i) begin
                    load_o = 1'b1;
                    s_d.st = ST_SEND;
                end
            end
            ST_SEND: begin
                if (pop_i) begin
                    s_d.addr[30:0] = s_q.addr[30:0] + 31'(BEAT_BYTES);
                    s_d.cnt        = s_q.cnt - CNT_W'(1);
                    if (s_q.cnt == CNT_W'(1)) begin
                        s_d.ctrl[START_BIT] = 1'b0;
                        s_d.st              = ST_IDLE;
                    end else begin
                        s_d.st = ST_REQ;
                    end
                end
            end
            ST_ZERO: begin
                s_d.ctrl[START_BIT] = 1'b0;
                s_d.st              = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st   <= ST_IDLE;
            s_q.ctrl <= '0;
            s_q.addr <= '0;
            s_q.cnt  <= '0;
            s_q.err  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_addr_o = s_q.addr[30:0];
    assign ctrl_o     = s_q.ctrl;
    assign addr_o     = s_q.addr;
    assign cnt_o      = s_q.cnt;
    assign err_o      = s_q.err;
endmodule

// File: rtl/qwdma_channel.sv
module qwdma_channel
    import qwdma_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_wr_sel,
    input  logic [31:0]       cfg_wr_data,
    output logic [31:0]       ctrl_rd,
    output logic [31:0]       addr_rd,
    output logic [31:0]       count_rd,
    output logic              err_flag,
    output logic              mem_req,
    output logic [30:0]       mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              st_valid,
    output logic [DATA_W-1:0] st_data,
    input  logic              st_ready
);
    localparam int ALIGN_BITS = $clog2(DATA_W / 8);

    logic             reject, empty, load, pop;
    logic [CNT_W-1:0] cnt;

    assign pop = st_valid && st_ready;

    qwdma_start_check #(
        .CNT_W      (CNT_W),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_check (
        .mode_i    (cfg_wr_data[MODE_LSB +: 2]),
        .addr_lo_i (addr_rd[ALIGN_BITS-1:0]),
        .cnt_i     (cnt),
        .reject_o  (reject),
        .empty_o   (empty)
    );

    qwdma_seq #(
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (cfg_wr_en),
        .wr_sel_i    (cfg_wr_sel),
        .wr_data_i   (cfg_wr_data),
        .reject_i    (reject),
        .empty_i     (empty),
        .rsp_valid_i (mem_rsp_valid),
        .pop_i       (pop),
        .mem_req_o   (mem_req),
        .mem_addr_o  (mem_addr),
        .load_o      (load),
        .ctrl_o      (ctrl_rd),
        .addr_o      (addr_rd),
        .cnt_o       (cnt),
        .err_o       (err_flag)
    );

    qwdma_beat_buf #(
        .DATA_W (DATA_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .data_i  (mem_rsp_data),
        .ready_i (st_ready),
        .valid_o (st_valid),
        .data_o  (st_data)
    );

    assign count_rd = 32'(cnt);
endmodule

// File: rtl/qwdma_channel_chk.sv
module qwdma_channel_chk #(
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [31:0]       addr_rd,
    input logic [31:0]       count_rd,
    input logic              err_flag,
    input logic              mem_req,
    input logic [30:0]       mem_addr,
    input logic              mem_rsp_valid,
    input logic              st_valid,
    input logic [DATA_W-1:0] st_data,
    input logic              st_ready
);
    localparam int STEP = DATA_W / 8;

    logic outstanding;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= 1'b0;
        end else if (mem_req) begin
            outstanding <= 1'b1;
        end else if (mem_rsp_valid) begin
            outstanding <= 1'b0;
        end
    end

    // R7: a new read only when nothing is pending anywhere
    assert_one_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (!outstanding && !st_valid));

    // R3: memory traffic and stream output only while the start bit reads 1
    assert_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || st_valid) |-> busy);

    // R4: requested address is the current address register
    assert_req_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr == addr_rd[30:0]));

    // R6: held quadword under backpressure
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_data)));

    // R5: progress step per accepted quadword
    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready) |=>
            ((count_rd == $past(count_rd) - 32'd1) &&
             (addr_rd == {$past(addr_rd[31]), $past(addr_rd[30:0]) + 31'(STEP)})));

    // R9: error flag is sticky
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
endmodule

bind qwdma_channel qwdma_channel_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (ctrl_rd[8]),
    .addr_rd       (addr_rd),
    .count_rd      (count_rd),
    .err_flag      (err_flag),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .st_valid      (st_valid),
    .st_data       (st_data),
    .st_ready      (st_ready)
);

// File: tb/tb_qwdma_channel.sv
`timescale 1ns/1ps
module tb_qwdma_channel;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr_en = 1'b0;
    logic [1:0]   cfg_wr_sel = 2'd0;
    logic [31:0]  cfg_wr_data = 32'd0;
    logic [31:0]  ctrl_rd, addr_rd, count_rd;
    logic         err_flag, mem_req, st_valid;
    logic [30:0]  mem_addr;
    logic         mem_rsp_valid = 1'b0;
    logic [127:0] mem_rsp_data = '0;
    logic [127:0] st_data;
    logic         st_ready = 1'b1;

    always #2.5 clk = ~clk;

    qwdma_channel dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .ctrl_rd(ctrl_rd), .addr_rd(addr_rd),
        .count_rd(count_rd), .err_flag(err_flag), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .st_valid(st_valid), .st_data(st_data),
        .st_ready(st_ready)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] pat(input logic [30:0] a);
        logic [31:0] w;
        w = {1'b0, a};
        return {w ^ 32'h1111_1111, ~w, w + 32'h55, w};
    endfunction

    // memory model, sink and monitors, all at the falling edge
    int          cyc = 0;
    bit          rdy_slow = 1'b0;
    bit          pend = 1'b0;
    logic [30:0] pend_addr = '0;
    logic [30:0] exp_addr = '0;
    int          n_req = 0;
    int          n_beat = 0;
    int          exp_beats = 0;
    bit          done_due = 1'b0;
    bit          hold_due = 1'b0;
    logic [127:0] hold_data = '0;

    always @(negedge clk) begin
        cyc++;
        if (hold_due) begin
            chk(st_valid && (st_data == hold_data), "R6 held quadword", st_data, hold_data);
        end
        if (done_due) begin
            chk(ctrl_rd[8] == 1'b0, "R5 start bit clears after last beat", ctrl_rd[8], 0);
            done_due = 1'b0;
        end
        st_ready      = rdy_slow ? (cyc % 3 == 0) : 1'b1;
        mem_rsp_valid = pend;
        mem_rsp_data  = pend ? pat(pend_addr) : '0;
        pend          = mem_req;
        pend_addr     = mem_addr;
        if (mem_req) n_req++;
        if (st_valid && st_ready) begin
            chk(st_data == pat(exp_addr), "R4 quadword order/data", st_data, pat(exp_addr));
            exp_addr = exp_addr + 31'd16;
            n_beat++;
            if (n_beat == exp_beats) done_due = 1'b1;
        end
        hold_due  = st_valid && !st_ready;
        hold_data = st_data;
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_sel  = sel;
        cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 400 && ctrl_rd[8]; i++) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    // {addr, count, mode, slow ready, expected error flag afterwards}
    localparam logic [51:0] VEC [0:6] = '{
        {32'h0000_0100, 16'd1, 2'd0, 1'b0, 1'b0},
        {32'h0000_2000, 16'd5, 2'd0, 1'b0, 1'b0},
        {32'h0000_3F00, 16'd3, 2'd0, 1'b1, 1'b0},
        {32'h0000_0400, 16'd0, 2'd0, 1'b0, 1'b0},
        {32'h0000_0108, 16'd2, 2'd0, 1'b0, 1'b1},
        {32'h0000_0200, 16'd2, 2'd1, 1'b0, 1'b1},
        {32'h8000_0600, 16'd2, 2'd0, 1'b1, 1'b1}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ctrl_rd == 0 && addr_rd == 0 && count_rd == 0, "R1 registers at reset",
            {ctrl_rd, addr_rd, count_rd}, 0);
        chk(!err_flag && !mem_req && !st_valid, "R1 outputs at reset",
            {err_flag, mem_req, st_valid}, 0);
        rst_n = 1'b1;

        // R2 register select and readback
        wr(2'd2, 32'hABCD_0003);
        chk(count_rd == 32'd3, "R2 count readback upper bits zero", count_rd, 3);
        wr(2'd1, 32'h1234_5670);
        chk(addr_rd == 32'h1234_5670, "R2 address readback", addr_rd, 32'h1234_5670);
        wr(2'd0, 32'h0000_00F1);
        chk(ctrl_rd == 32'h0000_00F1 && !mem_req, "R2 control readback without start",
            ctrl_rd, 32'hF1);

        foreach (VEC[k]) begin
            logic [31:0] a;
            logic [15:0] n;
            logic [1:0]  m;
            bit          refused;
            int          req0;
            a = VEC[k][51:20];
            n = VEC[k][19:4];
            m = VEC[k][3:2];
            rdy_slow = VEC[k][1];
            refused = (a[3:0] != 0) || (m != 0);
            wr(2'd1, a);
            wr(2'd2, {16'h0, n});
            exp_addr  = a[30:0];
            n_beat    = 0;
            exp_beats = refused ? 0 : int'(n);
            req0      = n_req;
            wr(2'd0, {23'h0, 1'b1, 4'h0, m, 2'b00});
            if (refused) begin
                chk(ctrl_rd[8] == 1'b0 && !mem_req && err_flag, "R9 refused start",
                    {ctrl_rd[8], mem_req, err_flag}, 3'b001);
            end else if (n == 0) begin
                chk(ctrl_rd[8] == 1'b1 && !mem_req, "R8 zero count busy one cycle",
                    {ctrl_rd[8], mem_req}, 2'b10);
                @(negedge clk);
                chk(ctrl_rd[8] == 1'b0, "R8 zero count clears start", ctrl_rd[8], 0);
            end else begin
                chk(ctrl_rd[8] == 1'b1 && mem_req, "R3 start begins transfer",
                    {ctrl_rd[8], mem_req}, 2'b11);
            end
            wait_done();
            chk(n_beat == exp_beats, "R4 quadword count delivered", n_beat, exp_beats);
            chk(n_req - req0 == exp_beats, "R7 one read per quadword", n_req - req0, exp_beats);
            if (refused) begin
                chk(addr_rd == a && count_rd == {16'h0, n}, "R9 registers untouched",
                    {addr_rd, count_rd}, {a, 16'h0, n});
            end else begin
                chk(addr_rd == {a[31], a[30:0] + 31'(16 * int'(n))} && count_rd == 0,
                    "R5 final address and count", {addr_rd, count_rd},
                    {a[31], a[30:0] + 31'(16 * int'(n)), 32'h0});
            end
            chk(err_flag == VEC[k][0], "R9 sticky error flag", err_flag, VEC[k][0]);
        end

        // R10 writes during a transfer are ignored
        rdy_slow = 1'b1;
        wr(2'd1, 32'h0000_1000);
        wr(2'd2, 32'd4);
        exp_addr  = 31'h1000;
        n_beat    = 0;
        exp_beats = 4;
        wr(2'd0, 32'h0000_0100);
        wr(2'd1, 32'h0000_5000);
        wr(2'd2, 32'd99);
        wr(2'd0, 32'h0000_0000);
        chk(ctrl_rd[8] == 1'b1, "R10 control write ignored while busy", ctrl_rd[8], 1);
        chk(addr_rd[31:12] == 20'h00001, "R10 address write ignored while busy",
            addr_rd, 32'h1000);
        wait_done();
        chk(n_beat == 4, "R10 full transfer despite writes", n_beat, 4);
        chk(addr_rd == 32'h0000_1040 && count_rd == 0, "R10 final registers",
            {addr_rd, count_rd}, {32'h1040, 32'h0});

        // R1 reset clears the sticky flag
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!err_flag && ctrl_rd == 0 && count_rd == 0, "R1 reset clears state",
            {err_flag, ctrl_rd}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R3 watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule